// File: doc/BRIEF.md
# Byte-Register GPIO Controller with Interrupt Sources

This block is a bank of general-purpose pins. A processor reaches it over a simple byte-wide register bus, one byte per access. Each pin owns one control byte, and the byte carries three fields. Bit 2 is the drive enable. Bit 0 is the value to drive. Bit 1 is the sampled input level. A block of read-only summary bytes packs the sampled level of every pin eight to a byte, so software can poll many pins in a single read. A status byte records misuse of the pins.

The controller watches the external pin inputs for changes. A change updates the sampled bit of that pin. A change on a pin that is being driven is flagged as an error, but the new level is still taken.

Two pins are wired as interrupt sources. The level pin (pin 1) drives its interrupt line with its sampled level. The edge pin (pin 9) follows its level, and it also has a strobe input. The strobe forces pin 9 high and then low at once, which gives one short pulse on its line. After reset, pin 1 reads as high.

Top module: `gpio_byte_ctl`

## Requirements
- R1: After reset, every pin control byte is 0x00 except pin 1, which is 0x02. The status byte is 0, `irq_level_o` is 1, and `irq_edge_o`, `err_pulse_o` and `bus_rdata_o` are 0.
- R2: A write to a pin control byte at offset 8+n (n = 0..35) with bit 2 set in the data stores bits 7..2 and bit 0 as written, and sets bit 1 to a copy of data bit 0.
- R3: A write to a pin control byte with bit 2 clear in the data stores bits 7..2 and bit 0 as written, and leaves bit 1 at its previous value.
- R4: Offsets 0..7 are read-only summary bytes. Bit b of byte k is bit 1 of pin 8k+b, or 0 when that pin does not exist. Writes to these offsets change nothing.
- R5: Offsets 45..63 are unmapped. They read as 0x00, and writes to them change nothing.
- R6: When a pin input differs from its value in the previous cycle, bit 1 of that pin takes the new level at the next clock edge.
- R7: An input change on a pin whose bit 2 is set raises `err_pulse_o` for exactly one cycle and still updates bit 1. A change on a pin whose bit 2 is clear raises no error.
- R8: The status byte at offset 44 holds a sticky error flag in bit 0. An error sets it. A read of offset 44 returns it and clears it. An error in the same cycle as that read leaves it set.
- R9: `irq_level_o` equals bit 1 of pin 1.
- R10: A strobe cycle makes `irq_edge_o` high in the next cycle and clears bit 1 of pin 9. In all other cycles, `irq_edge_o` equals bit 1 of pin 9.
- R11: Read data appears on `bus_rdata_o` one cycle after the read request. It then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Bus access request in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| pins_i | input | 36 | External pin levels |
| nmi_strobe_i | input | 1 | One-cycle strobe for the edge pin |
| irq_level_o | output | 1 | Level interrupt from pin 1 |
| irq_edge_o | output | 1 | Edge interrupt from pin 9 |
| err_pulse_o | output | 1 | One-cycle error flag |

## Verification
Every result here is one register stage after its cause. A read issued in cycle N has its data on `bus_rdata_o` in cycle N+1. A pin change, a strobe or an error is visible on the interrupt lines, the error pulse and the stored byte in the cycle after the input is presented. The bench drives inputs on the falling edge. The read scoreboard stamps each expected byte with the cycle index it is due in, and compares it on the falling edge of exactly that cycle. Output checks on the interrupt and error lines are taken one falling edge after the stimulus, and the one-cycle pulses are checked again on the next falling edge to confirm they have dropped.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
    typedef logic [7:0] byte_t;

    // Field positions inside a pin control byte
    localparam int OE_POS = 2;   // drive enable
    localparam int IN_POS = 1;   // sampled input level
    localparam int DO_POS = 0;   // drive value
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_ctl_pkg::*;
(
    input  byte_t cur_i,
    input  logic  wr_i,
    input  byte_t wdata_i,
    input  logic  evt_i,
    input  logic  lvl_i,
    input  logic  strobe_i,
    output byte_t nxt_o,
    output logic  err_o
);
    byte_t after_wr;

    always_comb begin
        after_wr = cur_i;
        if (wr_i) begin
            after_wr         = wdata_i;
            after_wr[IN_POS] = wdata_i[OE_POS] ? wdata_i[DO_POS] : cur_i[IN_POS];
        end
        nxt_o = after_wr;
        err_o = evt_i && after_wr[OE_POS];
        if (evt_i)    nxt_o[IN_POS] = lvl_i;
        if (strobe_i) nxt_o[IN_POS] = 1'b0;
    end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_ctl_pkg::*;
#(
    parameter int NUM_LEVEL = 8,
    parameter int NUM_PIN   = 36,
    parameter int ADDR_W    = 6
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [NUM_PIN-1:0][7:0]  pins_i,
    input  logic                     sticky_i,
    output byte_t                    rdata_o
);
    localparam int STAT_OFS = NUM_LEVEL + NUM_PIN;

    logic [NUM_LEVEL-1:0][7:0] lvl;

    for (genvar k = 0; k < NUM_LEVEL; k++) begin : g_lvl_byte
        for (genvar b = 0; b < 8; b++) begin : g_lvl_bit
            if (8 * k + b < NUM_PIN) begin : g_real
                assign lvl[k][b] = pins_i[8 * k + b][IN_POS];
            end else begin : g_none
                assign lvl[k][b] = 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_LEVEL; k++)
            if (int'(addr_i) == k) rdata_o = lvl[k];
        for (int j = 0; j < NUM_PIN; j++)
            if (int'(addr_i) == NUM_LEVEL + j) rdata_o = pins_i[j];
        if (int'(addr_i) == STAT_OFS) rdata_o = {7'b0, sticky_i};
    end
endmodule

// File: rtl/gpio_byte_ctl.sv
module gpio_byte_ctl
    import gpio_ctl_pkg::*;
#(
    parameter int NUM_LEVEL = 8,
    parameter int NUM_PIN   = 36,
    parameter int ADDR_W    = 6,
    parameter int LVL_PIN   = 1,
    parameter int EDGE_PIN  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [7:0]         bus_wdata_i,
    output logic [7:0]         bus_rdata_o,
    input  logic [NUM_PIN-1:0] pins_i,
    input  logic               nmi_strobe_i,
    output logic               irq_level_o,
    output logic               irq_edge_o,
    output logic               err_pulse_o
);
    localparam int PIN_BASE = NUM_LEVEL;
    localparam int STAT_OFS = NUM_LEVEL + NUM_PIN;

    typedef struct packed {
        logic [NUM_PIN-1:0][7:0] pins;
        logic [NUM_PIN-1:0]      prev;
        logic [7:0]              rdata;
        logic                    sticky;
        logic                    err;
        logic                    irq_edge;
    } state_t;

    state_t s_q, s_d;

    logic                    pin_hit, stat_hit, rd_req;
    logic [ADDR_W-1:0]       pin_idx;
    logic [NUM_PIN-1:0]      evt, cell_err, strobe_vec;
    logic [NUM_PIN-1:0][7:0] nxt_bus;
    byte_t                   rd_byte;

    assign pin_hit  = bus_sel_i && (int'(bus_addr_i) >= PIN_BASE)
                                && (int'(bus_addr_i) <  STAT_OFS);
    assign stat_hit = bus_sel_i && (int'(bus_addr_i) == STAT_OFS);
    assign rd_req   = bus_sel_i && !bus_wr_i;
    assign pin_idx  = bus_addr_i - ADDR_W'(PIN_BASE);
    assign evt      = pins_i ^ s_q.prev;

    always_comb begin
        strobe_vec           = '0;
        strobe_vec[EDGE_PIN] = nmi_strobe_i;
    end

    for (genvar i = 0; i < NUM_PIN; i++) begin : g_pin
        gpio_pin_cell u_cell (
            .cur_i    (s_q.pins[i]),
            .wr_i     (pin_hit && bus_wr_i && (pin_idx == ADDR_W'(i))),
            .wdata_i  (bus_wdata_i),
            .evt_i    (evt[i]),
            .lvl_i    (pins_i[i]),
            .strobe_i (strobe_vec[i]),
            .nxt_o    (nxt_bus[i]),
            .err_o    (cell_err[i])
        );
    end

    gpio_rd_mux #(
        .NUM_LEVEL (NUM_LEVEL),
        .NUM_PIN   (NUM_PIN),
        .ADDR_W    (ADDR_W)
    ) u_rd_mux (
        .addr_i   (bus_addr_i),
        .pins_i   (s_q.pins),
        .sticky_i (s_q.sticky),
        .rdata_o  (rd_byte)
    );

    always_comb begin
        s_d          = s_q;
        s_d.pins     = nxt_bus;
        s_d.prev     = pins_i;
        s_d.err      = |cell_err;
        s_d.irq_edge = nxt_bus[EDGE_PIN][IN_POS] | nmi_strobe_i;
        if (rd_req) s_d.rdata = rd_byte;
        if (rd_req && stat_hit) s_d.sticky = 1'b0;
        if (|cell_err) s_d.sticky = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q                       <= '0;
            s_q.pins[LVL_PIN][IN_POS] <= 1'b1;
            s_q.prev[LVL_PIN]         <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata_o = s_q.rdata;
    assign irq_level_o = s_q.pins[LVL_PIN][IN_POS];
    assign irq_edge_o  = s_q.irq_edge;
    assign err_pulse_o = s_q.err;

    // R2
    oe_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hit && bus_wr_i && bus_wdata_i[OE_POS] && !evt[pin_idx]
         && !(nmi_strobe_i && int'(pin_idx) == EDGE_PIN))
        |=> (s_q.pins[$past(pin_idx)][IN_POS] == $past(bus_wdata_i[DO_POS]))
            && (s_q.pins[$past(pin_idx)][7:2] == $past(bus_wdata_i[7:2])));

    // R3
    keep_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hit && bus_wr_i && !bus_wdata_i[OE_POS] && !evt[pin_idx]
         && !(nmi_strobe_i && int'(pin_idx) == EDGE_PIN))
        |=> s_q.pins[$past(pin_idx)][IN_POS] == $past(s_q.pins[pin_idx][IN_POS]));

    // R5
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && int'(bus_addr_i) > STAT_OFS) |=> bus_rdata_o == 8'h00);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> s_q.sticky);

    // R10
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_strobe_i |=> irq_edge_o && !s_q.pins[EDGE_PIN][IN_POS]);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata_o));
endmodule

// File: tb/tb_gpio_byte_ctl.sv
module tb_gpio_byte_ctl;
    localparam int NP = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wr = 1'b0, nmi = 1'b0;
    logic [5:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [NP-1:0] pins = '0;
    logic [7:0]    rdata;
    logic          irq_l, irq_e, err;

    always #2 clk = ~clk;   // 250 MHz

    gpio_byte_ctl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel_i    (sel),
        .bus_wr_i     (wr),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .pins_i       (pins),
        .nmi_strobe_i (nmi),
        .irq_level_o  (irq_l),
        .irq_edge_o   (irq_e),
        .err_pulse_o  (err)
    );

    typedef struct {
        int         due;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare read data in the cycle it is due
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].due == cyc) begin
            e = sb.pop_front();
            n_cmp++;
            if (rdata !== e.exp) begin
                n_bad++;
                $display("FAIL %s: rdata=%h expected %h", e.tag, rdata, e.exp);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr();
        sel = 1'b0; wr = 1'b0; nmi = 1'b0;
    endtask

    task automatic step();
        @(negedge clk); clr();
    endtask

    task automatic wr_b(input int a, input logic [7:0] d);
        @(negedge clk); clr();
        sel = 1'b1; wr = 1'b1; addr = 6'(a); wdata = d;
    endtask

    task automatic rd_b(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk); clr();
        sel = 1'b1; addr = 6'(a);
        sb.push_back('{cyc + 1, exp, tag});
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk); clr();
        pins[i] = v;
    endtask

    task automatic strobe();
        @(negedge clk); clr();
        nmi = 1'b1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        pins[1] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk({7'b0, irq_l}, 8'h01, "R1 irq_level");
        chk({7'b0, irq_e}, 8'h00, "R1 irq_edge");
        chk({7'b0, err},   8'h00, "R1 err");
        chk(rdata,         8'h00, "R1 rdata");
        rd_b(9,  8'h02, "R1 pin1 byte");
        rd_b(8,  8'h00, "R1 pin0 byte");
        rd_b(0,  8'h02, "R1 summary 0");
        rd_b(44, 8'h00, "R1 status");
        rd_b(17, 8'h00, "R1 pin9 byte");

        // R2 drive enable folds data into bit 1
        wr_b(11, 8'hA5);
        rd_b(11, 8'hA7, "R2 pin3 oe d1");
        wr_b(11, 8'h84);
        rd_b(11, 8'h84, "R2 pin3 oe d0");
        wr_b(14, 8'h06);
        rd_b(14, 8'h04, "R2 pin6 bit1 ignored");

        // R3 / R6 bit 1 kept on non-driving write
        set_pin(5, 1'b1);
        rd_b(13, 8'h02, "R6 pin5 rise");
        wr_b(13, 8'h31);
        rd_b(13, 8'h33, "R3 pin5 keep 1");
        wr_b(15, 8'h02);
        rd_b(15, 8'h00, "R3 pin7 keep 0");

        // R4 summary bytes
        wr_b(0, 8'hFF);
        rd_b(0, 8'h22, "R4 summary 0 after write");
        set_pin(34, 1'b1);
        rd_b(4,  8'h04, "R4 summary 4");
        rd_b(42, 8'h02, "R6 pin34");
        rd_b(5,  8'h00, "R4 summary 5 empty");
        rd_b(7,  8'h00, "R4 summary 7 empty");

        // R5 unmapped offsets
        wr_b(50, 8'h5A);
        rd_b(50, 8'h00, "R5 read 50");
        rd_b(63, 8'h00, "R5 read 63");
        rd_b(45, 8'h00, "R5 read 45");

        // R6 falling edge
        set_pin(5, 1'b0);
        rd_b(13, 8'h31, "R6 pin5 fall");

        // R7 error on driven pin
        set_pin(3, 1'b1);
        step();
        chk({7'b0, err}, 8'h01, "R7 err pulse high");
        step();
        chk({7'b0, err}, 8'h00, "R7 err pulse low");
        rd_b(11, 8'h86, "R7 pin3 still updated");
        set_pin(5, 1'b1);
        step();
        chk({7'b0, err}, 8'h00, "R7 no err when not driven");

        // R8 sticky status
        rd_b(44, 8'h01, "R8 status set");
        rd_b(44, 8'h00, "R8 status cleared");
        @(negedge clk); clr();
        pins[3] = 1'b0; sel = 1'b1; addr = 6'd44;
        sb.push_back('{cyc + 1, 8'h00, "R8 read same cycle as error"});
        rd_b(44, 8'h01, "R8 set wins over clear");
        rd_b(44, 8'h00, "R8 cleared again");

        // R9 level interrupt
        set_pin(1, 1'b0);
        step();
        chk({7'b0, irq_l}, 8'h00, "R9 irq_level low");
        rd_b(9, 8'h00, "R9 pin1 byte low");
        set_pin(1, 1'b1);
        step();
        chk({7'b0, irq_l}, 8'h01, "R9 irq_level high");

        // R10 edge interrupt and strobe
        strobe();
        step();
        chk({7'b0, irq_e}, 8'h01, "R10 strobe pulse");
        step();
        chk({7'b0, irq_e}, 8'h00, "R10 strobe pulse end");
        rd_b(17, 8'h00, "R10 pin9 after strobe");
        set_pin(9, 1'b1);
        step();
        chk({7'b0, irq_e}, 8'h01, "R10 follows pin9 high");
        rd_b(17, 8'h02, "R10 pin9 high");
        strobe();
        step();
        chk({7'b0, irq_e}, 8'h01, "R10 strobe while high");
        step();
        chk({7'b0, irq_e}, 8'h00, "R10 cleared by strobe");
        rd_b(17, 8'h00, "R10 pin9 cleared");
        set_pin(9, 1'b0);
        step();
        chk({7'b0, irq_e}, 8'h00, "R10 stays low");

        // R11 read latency and hold
        rd_b(9, 8'h02, "R11 read pin1");
        step();
        step();
        chk(rdata, 8'h02, "R11 rdata held");

        step();
        step();
        chk(8'(sb.size()), 8'h00, "R11 scoreboard drained");
        finish_run();
    end
endmodule